// File: doc/BRIEF.md
# Two-Phase Fan-Out Routing Node

This block is a one-input, two-output demultiplexing node for a network built from transition-signalled channels. A producer presents a data word together with a route bit, then toggles its request wire. The node copies the word into the holding register of the output that the route bit selects and toggles that output's request wire once. It then toggles the input acknowledge, which tells the producer that it may present the next item. Each consumer answers with one toggle on its own acknowledge wire, which empties that output's register.

The node is modelled in synchronous RTL. Every handshake wire is sampled on one clock, and a change of level counts as one event. Each output has its own register and controller. An output whose consumer is slow therefore never blocks items that are routed to the other output. An item aimed at an occupied output waits at the input, and the input acknowledge stays where it is until that output drains.

Top module: `fanout_route_node`

## Requirements
- R1: While `rst_n` is low at a clock edge, every request and acceptance phase bit is cleared and both holding registers are emptied and zeroed. After reset, `out_req`, `in_ack` and `out_data` all read zero.
- R2: An input event (`in_req` != `in_ack`) with `in_route` = 0 and output 0 free toggles `out_req[0]` at the next clock edge and puts the sampled word on `out_data[DATA_W-1:0]`.
- R3: An input event with `in_route` = 1 and output 1 free toggles `out_req[1]` at the next clock edge and puts the sampled word on `out_data[2*DATA_W-1:DATA_W]`.
- R4: Each accepted item toggles exactly one output request, exactly once. The request and data of the other output are left unchanged.
- R5: `in_ack` toggles exactly once for each accepted item, at the same clock edge as the output request. It never changes while there is no input event.
- R6: When `in_req` equals `in_ack`, no output changes, whatever values `in_data` and `in_route` carry.
- R7: An output is busy while `out_req[p]` != `out_ack[p]`. While it is busy, its request level and its data word do not change.
- R8: An item routed to a busy output is held. `in_ack` and that output stay unchanged until the clock edge at which the returned acknowledge matches the request level, and the item is accepted at that edge.
- R9: While output 0 is busy and stalled, several consecutive items routed to output 1 are each delivered and acknowledged, and output 0 keeps its word.
- R10: Words reach each output in the order they were sent to it, with the value that `in_data` held at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all handshake wires |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Input request phase; a toggle announces a new item |
| in_route | input | 1 | Selects the output for the current item (0 or 1) |
| in_data | input | DATA_W | Input word, stable before the request toggle |
| in_ack | output | 1 | Input acknowledge phase, the XOR of the per-output acceptance phases |
| out_req | output | 2 | Request phase of each output, bit p for output p |
| out_data | output | 2*DATA_W | Holding register of output p in bits [p*DATA_W +: DATA_W] |
| out_ack | input | 2 | Acknowledge phase returned by the consumer of each output |

## Verification
The embedded properties check on every cycle that a busy output keeps its request and word frozen, that at most one output accepts in any cycle, that `in_ack` moves only when there is an input event, and that it stays put while the targeted output is busy. Only the bench scenarios can show that words arrive at the right output in the right order with the right values. They also show the exact cycle at which a held item is released after a late acknowledge, and that a stalled output 0 lets a run of items through to output 1.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

    localparam int unsigned NPORT = 2;

    typedef enum logic {
        PORT_LO = 1'b0,
        PORT_HI = 1'b1
    } port_sel_e;

endpackage

// File: rtl/fanout_route_decode.sv
module fanout_route_decode
    import fanout_pkg::*;
(
    input  logic             evt_req,
    input  logic             evt_ack,
    input  logic             route,
    input  logic [NPORT-1:0] port_free,
    output logic             pending,
    output logic             blocked,
    output logic [NPORT-1:0] take
);

    port_sel_e sel;

    always_comb begin
        sel     = port_sel_e'(route);
        pending = evt_req ^ evt_ack;
        take    = '0;
        blocked = 1'b0;
        if (pending) begin
            if (port_free[sel]) begin
                take[sel] = 1'b1;
            end else begin
                blocked = 1'b1;
            end
        end
    end

    // R4: one output at most claims an item in any cycle
    always_comb begin
        assert_single_take_R4: assert ($onehot0(take));
    end

endmodule

// File: rtl/fanout_port_slot.sv
module fanout_port_slot #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    input  logic              ack_in,
    output logic              req_out,
    output logic              acc_out,
    output logic [DATA_W-1:0] data_out,
    output logic              free
);

    typedef struct packed {
        logic              req;
        logic              acc;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.data = din;
            st_d.req  = ~st_q.req;
            st_d.acc  = ~st_q.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign free     = (st_q.req == ack_in);
    assign req_out  = st_q.req;
    assign acc_out  = st_q.acc;
    assign data_out = st_q.data;

    // R7: an occupied register keeps its request phase and its word
    assert_busy_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != ack_in) |=> $stable(req_out));
    assert_busy_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != ack_in) |=> $stable(data_out));

endmodule

// File: rtl/fanout_route_node.sv
module fanout_route_node
    import fanout_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_req,
    input  logic                    in_route,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    in_ack,
    output logic [NPORT-1:0]        out_req,
    output logic [NPORT*DATA_W-1:0] out_data,
    input  logic [NPORT-1:0]        out_ack
);

    logic [NPORT-1:0] port_free;
    logic [NPORT-1:0] port_take;
    logic [NPORT-1:0] port_acc;
    logic             evt_pending;
    logic             evt_blocked;

    fanout_route_decode u_decode (
        .evt_req   (in_req),
        .evt_ack   (in_ack),
        .route     (in_route),
        .port_free (port_free),
        .pending   (evt_pending),
        .blocked   (evt_blocked),
        .take      (port_take)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fanout_port_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (port_take[p]),
            .din      (in_data),
            .ack_in   (out_ack[p]),
            .req_out  (out_req[p]),
            .acc_out  (port_acc[p]),
            .data_out (out_data[p*DATA_W +: DATA_W]),
            .free     (port_free[p])
        );
    end

    assign in_ack = ^port_acc;

    // R5: acknowledge moves only in answer to an input event
    assert_ack_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req == in_ack) |=> $stable(in_ack));
    // R8: acknowledge withheld while the targeted output is occupied
    assert_hold_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_blocked |=> $stable(in_ack));
    // R6: outputs frozen with no input event
    assert_idle_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req == in_ack) |=> $stable(out_req));
    // R4: an item toggles no more than one output request
    assert_one_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pending |=> ($countones(out_req ^ $past(out_req)) <= 1));

endmodule

// File: tb/tb_fanout_route_node.sv
module tb_fanout_route_node;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_req = 1'b0;
    logic          in_route = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ack;
    logic [1:0]    out_req;
    logic [2*DW-1:0] out_data;
    logic [1:0]    out_ack = 2'b00;

    fanout_route_node #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_route(in_route),
        .in_data(in_data), .in_ack(in_ack), .out_req(out_req),
        .out_data(out_data), .out_ack(out_ack)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference: per-port phase and stored word
    bit [1:0]    m_req = '0;
    bit [1:0]    m_acc = '0;
    bit [DW-1:0] m_data [2] = '{default: '0};

    bit [DW:0]   src_q [$];
    bit [DW-1:0] exp_q0 [$];
    bit [DW-1:0] exp_q1 [$];
    bit [1:0]    stall = 2'b00;
    int          got [2] = '{0, 0};
    bit          done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic deliver(input int p, input bit [DW-1:0] w);
        bit [DW-1:0] e;
        if (p == 0) begin
            if (exp_q0.size() == 0) begin chk(0, "R10", "unexpected word port0", w, 0); return; end
            e = exp_q0.pop_front();
        end else begin
            if (exp_q1.size() == 0) begin chk(0, "R10", "unexpected word port1", w, 0); return; end
            e = exp_q1.pop_front();
        end
        chk(w == e, "R10", "delivered word order/value", w, e);
        got[p]++;
    endtask

    task automatic step();
        bit pend;
        bit [DW:0] it;
        @(negedge clk);
        chk(out_req === m_req, tag, "out_req", out_req, m_req);
        chk(in_ack === (m_acc[0] ^ m_acc[1]), tag, "in_ack", in_ack, m_acc[0] ^ m_acc[1]);
        chk(out_data === {m_data[1], m_data[0]}, tag, "out_data", out_data, {m_data[1], m_data[0]});
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (!stall[p] && (out_req[p] != out_ack[p])) begin
                    deliver(p, out_data[p*DW +: DW]);
                    out_ack[p] = ~out_ack[p];
                end
            end
            if ((in_req == (m_acc[0] ^ m_acc[1])) && src_q.size() > 0) begin
                it = src_q.pop_front();
                in_route = it[DW];
                in_data  = it[DW-1:0];
                in_req   = ~in_req;
            end else if (in_req == (m_acc[0] ^ m_acc[1])) begin
                in_data  = in_data + 8'h5b;   // noise while idle (R6)
                in_route = ~in_route;
            end
        end
        if (!rst_n) begin
            m_req = '0; m_acc = '0; m_data[0] = '0; m_data[1] = '0;
        end else begin
            pend = in_req != (m_acc[0] ^ m_acc[1]);
            if (pend && (m_req[in_route] == out_ack[in_route])) begin
                m_data[in_route] = in_data;
                m_req[in_route]  = ~m_req[in_route];
                m_acc[in_route]  = ~m_acc[in_route];
            end
        end
    endtask

    task automatic send(input bit r, input bit [DW-1:0] w);
        src_q.push_back({r, w});
        if (r) exp_q1.push_back(w); else exp_q0.push_back(w);
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit; i++) begin
            step();
            if (src_q.size() == 0 && in_req == in_ack && out_req == out_ack) break;
        end
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit [1:0] r0;
        bit a0;
        bit [DW-1:0] d0;
        int g1;
        tag = "R1";
        step(); step();
        rst_n = 1'b1;
        step();
        chk(out_req === 2'b00 && in_ack === 1'b0 && out_data === '0, "R1",
            "reset state", {out_req, in_ack}, 0);

        tag = "R6";
        for (int i = 0; i < 6; i++) step();

        tag = "R2";
        send(0, 8'h3c);
        step(); step();
        chk(out_req[0] == 1'b1 && out_data[DW-1:0] == 8'h3c, "R2", "port0 capture",
            {out_req, out_data[DW-1:0]}, {2'b01, 8'h3c});
        drain(20);

        tag = "R3";
        send(1, 8'hc5);
        step(); step();
        chk(out_req[1] == 1'b1 && out_data[2*DW-1:DW] == 8'hc5, "R3", "port1 capture",
            {out_req, out_data[2*DW-1:DW]}, {2'b11, 8'hc5});
        drain(20);

        tag = "R4";
        for (int i = 0; i < 24; i++) send(1'((i * 7 + 3) % 5 > 1), 8'(i * 37 + 1));
        drain(400);
        chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R4", "all words delivered",
            exp_q0.size() + exp_q1.size(), 0);

        // R9: output 0 occupied and stalled, output 1 keeps flowing
        tag = "R9";
        stall = 2'b01;
        send(0, 8'ha1);
        for (int i = 0; i < 4; i++) step();
        chk(out_req[0] != out_ack[0], "R9", "port0 busy", out_req[0], ~out_ack[0]);
        g1 = got[1];
        for (int i = 0; i < 4; i++) send(1, 8'h70 + 8'(i));
        for (int i = 0; i < 20; i++) step();
        chk(got[1] - g1 == 4, "R9", "port1 deliveries while port0 stalled", got[1] - g1, 4);
        chk(out_data[DW-1:0] == 8'ha1, "R9", "port0 word kept", out_data[DW-1:0], 8'ha1);

        // R8: item aimed at busy output 0 is held
        tag = "R8";
        send(0, 8'hb2);
        step(); step();
        r0 = out_req; a0 = in_ack; d0 = out_data[DW-1:0];
        for (int i = 0; i < 5; i++) step();
        chk(in_ack == a0, "R8", "in_ack withheld", in_ack, a0);
        chk(out_req == r0 && out_data[DW-1:0] == d0, "R8", "port0 unchanged while busy",
            {out_req, out_data[DW-1:0]}, {r0, d0});
        stall = 2'b00;
        step();   // sink returns ack at this negedge
        step();   // accepted at the edge that sees the ack
        chk(in_ack != a0, "R8", "in_ack released", in_ack, ~a0);
        chk(out_data[DW-1:0] == 8'hb2, "R8", "held word captured", out_data[DW-1:0], 8'hb2);
        drain(40);

        // R5 and R7: a stalled output 1 with mixed traffic
        tag = "R7";
        stall = 2'b10;
        send(1, 8'h11); send(0, 8'h22); send(0, 8'h33); send(1, 8'h44);
        for (int i = 0; i < 12; i++) step();
        stall = 2'b00;
        tag = "R5";
        drain(60);
        chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R5", "queues empty at end",
            exp_q0.size() + exp_q1.size(), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule